// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block runs the two-phase training handshake that brings a DisplayPort main link up with a sink. A one-cycle start pulse, together with a lane count of 1, 2 or 4, launches one attempt. The sequencer first runs clock recovery under training pattern 1 and then channel equalization under training pattern 2. It finishes by turning the pattern off and reports the outcome on a one-cycle done strobe with a pass flag.

All sink accesses go through an abstract auxiliary-channel port. The block holds a request that carries a direction, a register address, a byte count and write data. The responder answers with a one-cycle acknowledge, read data and an error flag. Between status polls the sequencer waits fixed intervals, counted in clock cycles derived from the `CLK_HZ` parameter. Whatever swing and pre-emphasis it commits to the sink, it also drives per lane to the transmitter.

Top module: `lt_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `aux_req_o` are low, and every lane's swing and pre-emphasis output is 0.
- R2: A pattern is selected by a 1-byte read of address 0x102, followed by a 1-byte write of the same byte with only bits [1:0] replaced (1 for clock recovery, 2 for equalization). Bits [7:2] keep the value that was read.
- R3: Each clock-recovery pass writes 4 lane-set bytes to 0x103 (lane n in write byte n) and then waits at least 100 µs. It then reads 6 status bytes from 0x202, with the first returned byte in `aux_rdata_i[7:0]`. A request stays asserted, with a stable address, until it is acknowledged.
- R4: The drive request for lane n is the nibble of status byte 4+n/2: the low nibble for even n and the high nibble for odd n. Its bits [1:0] are the swing and bits [3:2] the pre-emphasis. The lane-set byte is pre-emphasis in bits [4:3] and swing in bits [1:0]. Bit 2 is set when the swing is 3 and bit 5 when the pre-emphasis is 3. Inactive lanes get 0x00. `swing_o`/`preemph_o` show the committed values, 2 bits per lane, with lane n at bits [2n+1:2n].
- R5: Lane n's status is the nibble of status byte n/2 with the same packing: bit 0 is CR-done, bit 1 is EQ-done and bit 2 is symbol-locked. Clock recovery succeeds, and equalization starts, as soon as every active lane shows CR-done.
- R6: Clock recovery stops with failure when the lowest-numbered active lane lacking CR-done was last committed with its max-swing flag set.
- R7: Clock recovery counts tries and clears the count whenever lane 0's committed swing differs from the previously recorded swing. It fails after five consecutive passes at an unchanged swing.
- R8: Each equalization pass waits at least 400 µs and then reads status. It succeeds when status byte 2 bit 0 (lanes aligned) is set and every active lane shows CR-done, EQ-done and symbol-locked.
- R9: Every equalization check is followed by a lane-set commit built from the new status. Equalization fails if any active lane has lost CR-done, or after its sixth unsuccessful check.
- R10: Status is cleared when an attempt starts, so the first commit of the attempt writes all-zero lane-set bytes.
- R11: An acknowledge with the error flag set ends the attempt at once: `done_o` rises in the next cycle with `pass_o` low, and no further requests are issued.
- R12: A start pulse while `busy_o` is high has no effect. `done_o` is a single-cycle strobe, and the block is idle in the cycle after it.
- R13: After clock recovery fails, or after equalization passes or fails, the pattern field is set back to 0 using the read-modify-write of R2 before `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches a training attempt |
| lanes_i | input | 3 | Active lane count (1, 2 or 4), sampled with start |
| aux_req_o | output | 1 | Auxiliary request pending |
| aux_wr_o | output | 1 | 1 = write, 0 = read |
| aux_addr_o | output | 20 | Sink register address |
| aux_len_o | output | 3 | Byte count of the access |
| aux_wdata_o | output | 8*MAX_LANES | Write bytes, first byte in [7:0] |
| aux_ack_i | input | 1 | One-cycle completion of the pending request |
| aux_err_i | input | 1 | Completion carries an error |
| aux_rdata_i | input | 48 | Read bytes, first byte in [7:0] |
| swing_o | output | 2*MAX_LANES | Committed voltage swing per lane |
| preemph_o | output | 2*MAX_LANES | Committed pre-emphasis per lane |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | One-cycle end-of-attempt strobe |
| pass_o | output | 1 | Attempt result, valid with done_o |

## Verification
Two events can fall in the same clock edge: a start request arriving and an auxiliary completion that advances the sequence. The bench provokes this by raising `start_i` on the very negative edge at which it returns the acknowledge for the pattern-1 write, so both are sampled together. It also changes the requested lane count at that moment. The result is judged by the scoreboard: every later transaction, including the 4-lane commit that decodes the high nibble of status byte 5, must match the original attempt exactly, and the final outputs must show the 4-lane settings.

// File: rtl/lt_pkg.sv
// Shared constants and state encoding for the link training sequencer.
// Assumes sink register addresses fit in 20 bits and status reads are 6 bytes.
package lt_pkg;
    localparam int AUX_AW     = 20;
    localparam int STAT_BYTES = 6;
    localparam int STAT_W     = 8 * STAT_BYTES;

    localparam logic [AUX_AW-1:0] REG_PATTERN = 20'h00102;
    localparam logic [AUX_AW-1:0] REG_LANESET = 20'h00103;
    localparam logic [AUX_AW-1:0] REG_STATUS  = 20'h00202;

    localparam logic [1:0] PAT_OFF = 2'd0;
    localparam logic [1:0] PAT_CR  = 2'd1;
    localparam logic [1:0] PAT_EQ  = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE, S_CR_PRD, S_CR_PWR, S_CR_SET, S_CR_WAIT, S_CR_STAT, S_CR_EVAL,
        S_EQ_PRD, S_EQ_PWR, S_EQ_WAIT, S_EQ_STAT, S_EQ_EVAL, S_EQ_SET,
        S_FN_PRD, S_FN_PWR, S_DONE
    } seq_state_t;
endpackage

// File: rtl/lt_timer.sv
// One-shot interval timer. A load arms it with a cycle count; fire_o is
// high for one cycle once that many cycles have elapsed. Assumes count_i >= 1.
module lt_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] count_i,
    output logic          fire_o
);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign fire_o = run_q && (cnt_q == '0);

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= count_i - 1'b1;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/lt_lane_decode.sv
// Per-lane status and drive-request decoder. Lane n reads its status nibble
// from byte n/2 and its request nibble from byte 4+n/2 (low nibble = even lane).
// Assumes LANES <= 4 so both nibble groups fit in two bytes.
module lt_lane_decode #(
    parameter int LANES = 4
) (
    input  logic [lt_pkg::STAT_W-1:0] stat_i,
    input  logic [LANES-1:0]          active_i,
    input  logic [LANES-1:0]          maxsw_i,
    output logic [8*LANES-1:0]        set_o,
    output logic                      cr_all_o,
    output logic                      eq_all_o,
    output logic                      abort_o
);
    logic [LANES-1:0] cr_l;
    logic [LANES-1:0] eq_l;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SB = (i / 2) * 8 + (i % 2) * 4;
        localparam int RB = 32 + SB;
        logic [2:0] st;
        logic [1:0] swing;
        logic [1:0] pre;
        assign st    = stat_i[SB +: 3];
        assign swing = stat_i[RB +: 2];
        assign pre   = stat_i[RB + 2 +: 2];
        assign cr_l[i] = st[0];
        assign eq_l[i] = &st;
        assign set_o[8*i +: 8] = active_i[i] ?
            {2'b00, pre == 2'd3, pre, swing == 2'd3, swing} : 8'h00;
    end

    assign cr_all_o = &(cr_l | ~active_i);
    assign eq_all_o = &(eq_l | ~active_i);

    // Abort when the first active lane lacking CR-done already sits at max swing.
    always_comb begin
        logic found;
        found   = 1'b0;
        abort_o = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (!found && active_i[i] && !cr_l[i]) begin
                found   = 1'b1;
                abort_o = maxsw_i[i];
            end
        end
    end
endmodule

// File: rtl/lt_seq.sv
// Link training sequencer top: clock recovery, then equalization, then pattern
// off, all through a request/acknowledge auxiliary port. Assumes the responder
// acknowledges each request with a single-cycle ack and MAX_LANES <= 4.
module lt_seq #(
    parameter int CLK_HZ         = 125_000_000,
    parameter int MAX_LANES      = 4,
    parameter int CR_WAIT_US     = 100,
    parameter int EQ_WAIT_US     = 400,
    parameter int CR_TRY_LIMIT   = 5,
    parameter int EQ_RETRY_LIMIT = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [2:0]                    lanes_i,
    output logic                          aux_req_o,
    output logic                          aux_wr_o,
    output logic [lt_pkg::AUX_AW-1:0]     aux_addr_o,
    output logic [2:0]                    aux_len_o,
    output logic [8*MAX_LANES-1:0]        aux_wdata_o,
    input  logic                          aux_ack_i,
    input  logic                          aux_err_i,
    input  logic [lt_pkg::STAT_W-1:0]     aux_rdata_i,
    output logic [2*MAX_LANES-1:0]        swing_o,
    output logic [2*MAX_LANES-1:0]        preemph_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          pass_o
);
    import lt_pkg::*;

    localparam int CR_CYC = (CLK_HZ / 1_000_000) * CR_WAIT_US;
    localparam int EQ_CYC = (CLK_HZ / 1_000_000) * EQ_WAIT_US;
    localparam int CW     = $clog2((CR_CYC > EQ_CYC ? CR_CYC : EQ_CYC) + 1);
    localparam int TW     = $clog2(CR_TRY_LIMIT + EQ_RETRY_LIMIT + 2);

    seq_state_t             state_q;
    logic [MAX_LANES-1:0]   active_q;
    logic [STAT_W-1:0]      stat_q;
    logic [8*MAX_LANES-1:0] conf_q;
    logic [7:0]             pat_q;
    logic [TW-1:0]          tries_q;
    logic [1:0]             volt_q;
    logic                   loop_q;
    logic                   pass_q;

    logic [MAX_LANES-1:0]   active_in, maxsw;
    logic [8*MAX_LANES-1:0] set_next;
    logic                   cr_all, eq_all, abort;
    logic                   ack_ok, ack_bad, tmr_load, tmr_fire;
    logic [CW-1:0]          tmr_count;
    logic [TW-1:0]          cr_base, cr_inc, eq_inc;

    // Active-lane mask from the requested lane count.
    always_comb begin
        for (int i = 0; i < MAX_LANES; i++) active_in[i] = (i < int'(lanes_i));
    end

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_drive
        assign maxsw[i]            = conf_q[8*i + 2];
        assign swing_o[2*i +: 2]   = conf_q[8*i +: 2];
        assign preemph_o[2*i +: 2] = conf_q[8*i + 3 +: 2];
    end

    lt_lane_decode #(.LANES(MAX_LANES)) u_dec (
        .stat_i   (stat_q),
        .active_i (active_q),
        .maxsw_i  (maxsw),
        .set_o    (set_next),
        .cr_all_o (cr_all),
        .eq_all_o (eq_all),
        .abort_o  (abort)
    );

    assign ack_ok    = aux_req_o && aux_ack_i && !aux_err_i;
    assign ack_bad   = aux_req_o && aux_ack_i && aux_err_i;
    assign tmr_load  = ack_ok && ((state_q == S_CR_SET) || (state_q == S_EQ_PWR) ||
                                  ((state_q == S_EQ_SET) && loop_q));
    assign tmr_count = (state_q == S_CR_SET) ? CW'(CR_CYC) : CW'(EQ_CYC);

    lt_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .count_i (tmr_count),
        .fire_o  (tmr_fire)
    );

    assign cr_base = (conf_q[1:0] != volt_q) ? '0 : tries_q;
    assign cr_inc  = cr_base + 1'b1;
    assign eq_inc  = tries_q + 1'b1;

    assign busy_o = (state_q != S_IDLE);
    assign done_o = (state_q == S_DONE);
    assign pass_o = pass_q;

    // Auxiliary request fields decoded from the current state.
    always_comb begin
        aux_req_o   = 1'b1;
        aux_wr_o    = 1'b0;
        aux_addr_o  = REG_PATTERN;
        aux_len_o   = 3'd1;
        aux_wdata_o = '0;
        case (state_q)
            S_CR_PRD, S_EQ_PRD, S_FN_PRD: ;
            S_CR_PWR: begin aux_wr_o = 1'b1; aux_wdata_o[7:0] = {pat_q[7:2], PAT_CR};  end
            S_EQ_PWR: begin aux_wr_o = 1'b1; aux_wdata_o[7:0] = {pat_q[7:2], PAT_EQ};  end
            S_FN_PWR: begin aux_wr_o = 1'b1; aux_wdata_o[7:0] = {pat_q[7:2], PAT_OFF}; end
            S_CR_SET, S_EQ_SET: begin
                aux_wr_o    = 1'b1;
                aux_addr_o  = REG_LANESET;
                aux_len_o   = 3'(MAX_LANES);
                aux_wdata_o = conf_q;
            end
            S_CR_STAT, S_EQ_STAT: begin
                aux_addr_o = REG_STATUS;
                aux_len_o  = 3'(STAT_BYTES);
            end
            default: aux_req_o = 1'b0;
        endcase
    end

    // Training sequence: phase control, retry bookkeeping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            active_q <= '0;
            stat_q   <= '0;
            conf_q   <= '0;
            pat_q    <= '0;
            tries_q  <= '0;
            volt_q   <= '0;
            loop_q   <= 1'b0;
            pass_q   <= 1'b0;
        end else if (ack_bad) begin
            state_q <= S_DONE;
            pass_q  <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i) begin
                    active_q <= active_in;
                    stat_q   <= '0;
                    conf_q   <= '0;
                    tries_q  <= '0;
                    volt_q   <= '0;
                    pass_q   <= 1'b0;
                    state_q  <= S_CR_PRD;
                end
                S_CR_PRD: if (ack_ok) begin pat_q <= aux_rdata_i[7:0]; state_q <= S_CR_PWR; end
                S_CR_PWR: if (ack_ok) begin conf_q <= set_next; state_q <= S_CR_SET; end
                S_CR_SET: if (ack_ok) state_q <= S_CR_WAIT;
                S_CR_WAIT: if (tmr_fire) state_q <= S_CR_STAT;
                S_CR_STAT: if (ack_ok) begin stat_q <= aux_rdata_i; state_q <= S_CR_EVAL; end
                S_CR_EVAL: begin
                    volt_q <= conf_q[1:0];
                    if (cr_all) begin
                        tries_q <= '0;
                        state_q <= S_EQ_PRD;
                    end else if (abort || (int'(cr_inc) >= CR_TRY_LIMIT)) begin
                        state_q <= S_FN_PRD;
                    end else begin
                        tries_q <= cr_inc;
                        conf_q  <= set_next;
                        state_q <= S_CR_SET;
                    end
                end
                S_EQ_PRD: if (ack_ok) begin pat_q <= aux_rdata_i[7:0]; state_q <= S_EQ_PWR; end
                S_EQ_PWR: if (ack_ok) state_q <= S_EQ_WAIT;
                S_EQ_WAIT: if (tmr_fire) state_q <= S_EQ_STAT;
                S_EQ_STAT: if (ack_ok) begin stat_q <= aux_rdata_i; state_q <= S_EQ_EVAL; end
                S_EQ_EVAL: begin
                    pass_q  <= stat_q[16] && eq_all;
                    loop_q  <= !(stat_q[16] && eq_all) && cr_all &&
                               (int'(eq_inc) <= EQ_RETRY_LIMIT);
                    tries_q <= eq_inc;
                    conf_q  <= set_next;
                    state_q <= S_EQ_SET;
                end
                S_EQ_SET: if (ack_ok) state_q <= loop_q ? S_EQ_WAIT : S_FN_PRD;
                S_FN_PRD: if (ack_ok) begin pat_q <= aux_rdata_i[7:0]; state_q <= S_FN_PWR; end
                S_FN_PWR: if (ack_ok) state_q <= S_DONE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lt_seq_chk.sv
// Protocol and result checker for lt_seq, attached by bind.
module lt_seq_chk #(
    parameter int MAX_LANES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     aux_req_o,
    input logic                     aux_ack_i,
    input logic                     aux_err_i,
    input logic [19:0]              aux_addr_o,
    input logic [2*MAX_LANES-1:0]   swing_o,
    input logic [2*MAX_LANES-1:0]   preemph_o,
    input logic                     busy_o,
    input logic                     done_o,
    input logic                     pass_o
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_req_o && !aux_ack_i |=> aux_req_o && $stable(aux_addr_o));

    // R11
    err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_req_o && aux_ack_i && aux_err_i |=> done_o && !pass_o);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !aux_req_o);

    // R10
    clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (swing_o == '0) && (preemph_o == '0));
endmodule

bind lt_seq lt_seq_chk #(.MAX_LANES(MAX_LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .aux_req_o  (aux_req_o),
    .aux_ack_i  (aux_ack_i),
    .aux_err_i  (aux_err_i),
    .aux_addr_o (aux_addr_o),
    .swing_o    (swing_o),
    .preemph_o  (preemph_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pass_o     (pass_o)
);

// File: tb/lt_seq_test.sv
// Scoreboard bench: scenario tasks queue the expected auxiliary transactions
// with the responses to return; the responder process pops and compares them.
module lt_seq_test;
    localparam int CR_GAP = 200;
    localparam int EQ_GAP = 800;
    localparam logic [19:0] PAT = 20'h00102, SET = 20'h00103, STA = 20'h00202;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  lanes_i = 3'd1;
    logic        aux_req_o, aux_wr_o;
    logic [19:0] aux_addr_o;
    logic [2:0]  aux_len_o;
    logic [31:0] aux_wdata_o;
    logic        aux_ack_i = 1'b0;
    logic        aux_err_i = 1'b0;
    logic [47:0] aux_rdata_i = '0;
    logic [7:0]  swing_o, preemph_o;
    logic        busy_o, done_o, pass_o;

    int nvec = 0, nbad = 0, cyc = 0, last_ack = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          wr;
        logic [19:0] addr;
        int          len;
        logic [31:0] wdata;
        logic [47:0] rdata;
        bit          err;
        int          gap;
        bit          poke;
        string       tag;
    } item_t;
    item_t exp_q[$];

    lt_seq #(.CLK_HZ(2_000_000)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lanes_i(lanes_i),
        .aux_req_o(aux_req_o), .aux_wr_o(aux_wr_o), .aux_addr_o(aux_addr_o),
        .aux_len_o(aux_len_o), .aux_wdata_o(aux_wdata_o), .aux_ack_i(aux_ack_i),
        .aux_err_i(aux_err_i), .aux_rdata_i(aux_rdata_i), .swing_o(swing_o),
        .preemph_o(preemph_o), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(bit wr, logic [19:0] addr, int len, logic [31:0] wd,
                        logic [47:0] rd, bit err, int gap, bit poke, string tag);
        item_t it;
        it.wr = wr; it.addr = addr; it.len = len; it.wdata = wd; it.rdata = rd;
        it.err = err; it.gap = gap; it.poke = poke; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic prd(logic [7:0] ret, string tag);
        push(1'b0, PAT, 1, '0, {40'h0, ret}, 1'b0, 0, 1'b0, tag);
    endtask
    task automatic pwr(logic [7:0] val, bit poke, string tag);
        push(1'b1, PAT, 1, {24'h0, val}, '0, 1'b0, 0, poke, tag);
    endtask
    task automatic lset(logic [31:0] val, string tag);
        push(1'b1, SET, 4, val, '0, 1'b0, 0, 1'b0, tag);
    endtask
    task automatic stat(logic [47:0] ret, int gap, string tag);
        push(1'b0, STA, 6, '0, ret, 1'b0, gap, 1'b0, tag);
    endtask

    function automatic logic [47:0] sb(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                                       logic [7:0] b4, logic [7:0] b5);
        return {b5, b4, 8'h00, b2, b1, b0};
    endfunction

    // Responder/monitor: pops the next expected item, compares, answers.
    initial begin
        item_t it;
        bit poked = 1'b0;
        forever begin
            @(negedge clk);
            aux_ack_i = 1'b0;
            aux_err_i = 1'b0;
            if (poked) begin start_i = 1'b0; poked = 1'b0; end
            if (rst_n && aux_req_o) begin
                int seen;
                seen = cyc;
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R13 unexpected request", {43'h0, aux_wr_o, aux_addr_o}, '0);
                    it.rdata = '0; it.err = 1'b1; it.poke = 1'b0;
                end else begin
                    it = exp_q.pop_front();
                    check(aux_wr_o == it.wr && aux_addr_o == it.addr &&
                          int'(aux_len_o) == it.len && (!it.wr || aux_wdata_o == it.wdata),
                          it.tag, {aux_wr_o, aux_addr_o, 8'(aux_len_o), aux_wdata_o},
                          {it.wr, it.addr, 8'(it.len), it.wdata});
                    if (it.gap > 0)
                        check(seen - last_ack >= it.gap && seen - last_ack <= it.gap + 4,
                              it.tag, 64'(seen - last_ack), 64'(it.gap));
                end
                aux_rdata_i = it.rdata;
                aux_err_i   = it.err;
                aux_ack_i   = 1'b1;
                last_ack    = cyc;
                if (it.poke) begin start_i = 1'b1; lanes_i = 3'd1; poked = 1'b1; end
            end
        end
    end

    task automatic run(logic [2:0] n, bit exp_pass, string tag);
        @(negedge clk); start_i = 1'b1; lanes_i = n;
        @(negedge clk); start_i = 1'b0;
        check(busy_o, "R12 busy after start", 64'(busy_o), 64'd1);
        while (!done_o) @(negedge clk);
        check(pass_o == exp_pass, tag, 64'(pass_o), 64'(exp_pass));
        check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        check(!done_o && !busy_o, "R12 idle after done", {done_o, busy_o}, 64'd0);
    endtask

    task automatic cr_ok_2lane();
        prd(8'h00, "R2"); pwr(8'h01, 1'b0, "R2");
        lset(32'h0, "R10");
        stat(sb(8'h11, 8'h00, 8'h00, 8'h00, 8'h00), CR_GAP, "R3");
        prd(8'h01, "R5"); pwr(8'h02, 1'b0, "R2");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !aux_req_o, "R1 idle", {busy_o, done_o, aux_req_o}, 64'd0);
        check(swing_o == 8'h00 && preemph_o == 8'h00, "R1 drive", {swing_o, preemph_o}, 64'd0);

        // 4 lanes, success; start pulsed together with an ack (R12), R4 odd-lane decode
        prd(8'hA4, "R2"); pwr(8'hA5, 1'b1, "R2 R12");
        lset(32'h0, "R10");
        stat(sb(8'h11, 8'h11, 8'h00, 8'h01, 8'h00), CR_GAP, "R3");
        prd(8'hA5, "R5"); pwr(8'hA6, 1'b0, "R2");
        stat(sb(8'h77, 8'h77, 8'h01, 8'h01, 8'hE0), EQ_GAP, "R8");
        lset(32'h3A000001, "R4");
        prd(8'hA6, "R13"); pwr(8'hA4, 1'b0, "R13");
        run(3'd4, 1'b1, "R8 pass");
        check(swing_o == 8'h81, "R4 swing", 64'(swing_o), 64'h81);
        check(preemph_o == 8'hC0, "R4 preemph", 64'(preemph_o), 64'hC0);

        // 1 lane, abort at max swing (R6)
        prd(8'h00, "R2"); pwr(8'h01, 1'b0, "R2");
        lset(32'h0, "R10");
        stat(sb(8'h00, 8'h00, 8'h00, 8'h03, 8'h00), CR_GAP, "R3");
        lset(32'h00000007, "R6");
        stat(sb(8'h00, 8'h00, 8'h00, 8'h03, 8'h00), CR_GAP, "R6");
        prd(8'h01, "R6"); pwr(8'h00, 1'b0, "R13");
        run(3'd1, 1'b0, "R6 fail");
        check(swing_o == 8'h03, "R6 swing", 64'(swing_o), 64'h03);

        // 1 lane, swing change resets the try count (R7): six passes
        prd(8'h00, "R2"); pwr(8'h01, 1'b0, "R2");
        lset(32'h0, "R7");
        stat(sb(8'h00, 8'h00, 8'h00, 8'h01, 8'h00), CR_GAP, "R7");
        for (int k = 0; k < 5; k++) begin
            lset(32'h00000001, "R7");
            stat(sb(8'h00, 8'h00, 8'h00, 8'h01, 8'h00), CR_GAP, "R7");
        end
        prd(8'h01, "R7"); pwr(8'h00, 1'b0, "R13");
        run(3'd1, 1'b0, "R7 fail");

        // 2 lanes, equalization never locks: six checks (R9)
        cr_ok_2lane();
        for (int k = 0; k < 6; k++) begin
            stat(sb(8'h11, 8'h00, 8'h01, 8'h00, 8'h00), EQ_GAP, "R9");
            lset(32'h0, "R9");
        end
        prd(8'h02, "R9"); pwr(8'h00, 1'b0, "R13");
        run(3'd2, 1'b0, "R9 limit");

        // 2 lanes, lane 1 loses CR during equalization (R9)
        cr_ok_2lane();
        stat(sb(8'h01, 8'h00, 8'h01, 8'h00, 8'h00), EQ_GAP, "R9");
        lset(32'h0, "R9");
        prd(8'h02, "R9"); pwr(8'h00, 1'b0, "R13");
        run(3'd2, 1'b0, "R9 cr lost");

        // error on a status read ends the attempt (R11)
        prd(8'h00, "R2"); pwr(8'h01, 1'b0, "R2");
        lset(32'h0, "R10");
        push(1'b0, STA, 6, '0, '0, 1'b1, CR_GAP, 1'b0, "R11");
        run(3'd2, 1'b0, "R11 error");

        repeat (5) @(negedge clk);
        check(!aux_req_o && !busy_o, "R11 quiet", {aux_req_o, busy_o}, 64'd0);
        finish_run();
    end
endmodule